// File: doc/BRIEF.md
# Serial PHY Management Master

This block drives the two-wire management bus used to read and write registers inside Ethernet PHYs. A host raises a one-cycle request carrying a read/write flag, a 5-bit PHY address, a 5-bit register address and, for writes, 16 bits of data. The block then produces the whole management frame on its clock, data-out and output-enable pins and reports back with a one-cycle done pulse. The bidirectional data pad itself sits outside the block and is built from `mdo`, `md_oe` and `mdi`.

Every frame is a row of bit slots. Each slot has three phases of equal length: a setup phase with the clock low, a high phase and a low phase. The phase length is `div_cfg + 1` system clocks. `div_cfg` is captured when a request is accepted. A frame opens with 32 preamble slots with the data line high, followed by a 14-bit header. A write then drives an 18-slot tail. On a read the block releases the pin for those 18 slots. It treats the first sampled bit as an error flag and shifts the next 16 samples in as the read value. A raised error flag forces the returned value to zero.

Top module: `phy_mgmt_master`

## Requirements
- R1: Out of reset and whenever no frame is running: `busy`=0, `done`=0, `mdc`=0, `mdo`=1 and `md_oe`=1.
- R2: A request (`req_valid`=1 while `busy`=0) is accepted on that clock edge, and `busy` is 1 from the next cycle. The value of `div_cfg` at acceptance sets the phase length to `div_cfg`+1 clocks.
- R3: Every slot consists of, in order, a setup phase (`mdc`=0), a high phase (`mdc`=1) and a low phase (`mdc`=0).
- R4: The first 32 slots of every frame are preamble, with `mdo`=1 and `md_oe`=1.
- R5: The next 14 slots send, MSB first, the start code 01, then the opcode (read = 10, write = 01), then `req_phy`, then `req_reg`, all with `md_oe`=1.
- R6: On a write, the 18 closing slots send the turnaround code 10 and then `req_wdata`, MSB first, with `md_oe`=1.
- R7: On a read, the 18 closing slots have `md_oe`=0 and `mdo`=1. `mdi` is sampled on the last clock of the setup phase only. It is sampled in the second closing slot as the error bit, and in closing slots 3 to 18 as the read data, MSB first.
- R8: If the error bit of a read is 1, the data samples are discarded: `rd_data` is 0 and `rd_err` is 1.
- R9: `done` is high for exactly one cycle, the cycle right after the last frame cycle. In that cycle `busy`=0 and `md_oe`=1, and `rd_data`/`rd_err` hold the result. A write reports 0 and 0.
- R10: While `busy`=1, a new request is ignored, and changes on `div_cfg` do not alter the running frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | Register address |
| req_wdata | input | 16 | Write data |
| div_cfg | input | DIV_W | Phase length minus one, in system clocks |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| rd_data | output | 16 | Read result |
| rd_err | output | 1 | Read error flag |
| mdc | output | 1 | Management clock |
| mdo | output | 1 | Data value driven to the pin |
| md_oe | output | 1 | 1 = host drives the pin, 0 = PHY drives it |
| mdi | input | 1 | Data value seen on the pin |

## Verification
The bench builds the block with `DIV_W` = 4 and the default preamble length of 32. This keeps a whole frame at a few hundred to about a thousand clocks. Frames run with `div_cfg` at 0, 1, 2 and 3, so single-clock phases appear alongside stretched ones, and the bench flips `div_cfg` in the middle of frames.

The PHY responder drives the inverted bit outside the setup phase, so a sample taken at the wrong moment changes the read result. The bench runs one read with the error bit set and a data pattern of all ones. It also issues a request in the middle of a frame, which must be ignored.

// File: rtl/pmm_pkg.sv
// Shared constants and types for the serial PHY management master.
// Assumes the standard 14-bit header and an 18-slot tail per frame.
package pmm_pkg;
    localparam int ADDR_W    = 5;
    localparam int DATA_W    = 16;
    localparam int HDR_BITS  = 4 + 2 * ADDR_W;
    localparam int TAIL_BITS = 2 + DATA_W;
    localparam int FRAME_W   = HDR_BITS + TAIL_BITS;

    localparam logic [1:0] CODE_START = 2'b01;
    localparam logic [1:0] CODE_RD    = 2'b10;
    localparam logic [1:0] CODE_WR    = 2'b01;
    localparam logic [1:0] CODE_TA    = 2'b10;

    typedef enum logic [1:0] {
        PH_SETUP = 2'd0,
        PH_HIGH  = 2'd1,
        PH_LOW   = 2'd2
    } phase_t;
endpackage

// File: rtl/pmm_divider.sv
// Phase-interval divider: emits one tick every (div+1) clocks while run is high.
// Assumes start and run are never both high; div is captured on start.
module pmm_divider #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             run,
    input  logic [DIV_W-1:0] div_in,
    output logic             tick
);
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] cnt_q;

    // Capture the interval at frame start and count clocks within a phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
            cnt_q <= '0;
        end else if (start) begin
            div_q <= div_in;
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= (cnt_q == div_q) ? '0 : cnt_q + 1'b1;
        end
    end

    assign tick = run && (cnt_q == div_q);

    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= div_q));
endmodule

// File: rtl/pmm_sequencer.sv
// Slot and phase sequencer: walks the preamble, header and tail slots,
// three phases each, and flags the final edge of the frame.
// Assumes start arrives only while busy is low.
module pmm_sequencer
    import pmm_pkg::*;
#(
    parameter int PRE_N  = 32,
    parameter int SLOTS  = PRE_N + FRAME_W,
    parameter int SLOT_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              tick,
    output logic              busy,
    output logic              done,
    output logic              finish,
    output phase_t            phase,
    output logic [SLOT_W-1:0] slot
);
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

    assign finish = tick && (phase == PH_LOW) && (slot == LAST);

    // Advance the phase on every tick and the slot at the end of each low phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            done  <= 1'b0;
            phase <= PH_SETUP;
            slot  <= '0;
        end else begin
            done <= finish;
            if (start) begin
                busy  <= 1'b1;
                phase <= PH_SETUP;
                slot  <= '0;
            end else if (tick) begin
                case (phase)
                    PH_SETUP: phase <= PH_HIGH;
                    PH_HIGH:  phase <= PH_LOW;
                    default: begin
                        phase <= PH_SETUP;
                        if (finish) busy <= 1'b0;
                        else        slot <= slot + 1'b1;
                    end
                endcase
            end
        end
    end

    p_high_then_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && phase == PH_HIGH) |=> (phase == PH_LOW));
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/pmm_shifter.sv
// Frame data path: shifts the header and write tail out, releases the pin for
// the read tail, captures the error bit and read data, and forms the result.
// Assumes the slot, phase and tick timing comes from the sequencer.
module pmm_shifter
    import pmm_pkg::*;
#(
    parameter int PRE_N  = 32,
    parameter int SLOT_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_phy,
    input  logic [ADDR_W-1:0] req_reg,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              tick,
    input  phase_t            phase,
    input  logic [SLOT_W-1:0] slot,
    input  logic              finish,
    input  logic              mdi,
    output logic              tx_bit,
    output logic              drive,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_err
);
    localparam logic [SLOT_W-1:0] HDR_SLOT  = SLOT_W'(PRE_N);
    localparam logic [SLOT_W-1:0] TAIL_SLOT = SLOT_W'(PRE_N + HDR_BITS);
    localparam logic [SLOT_W-1:0] ERR_SLOT  = SLOT_W'(PRE_N + HDR_BITS + 1);
    localparam logic [SLOT_W-1:0] DATA_SLOT = SLOT_W'(PRE_N + HDR_BITS + 2);

    logic [FRAME_W-1:0] tx_sr;
    logic [DATA_W-1:0]  rx_sr;
    logic               rd_q;
    logic               err_q;
    logic               sample;

    assign sample = tick && (phase == PH_SETUP) && rd_q;
    assign tx_bit = (slot < HDR_SLOT) ? 1'b1 : tx_sr[FRAME_W-1];
    assign drive  = !(rd_q && (slot >= TAIL_SLOT));

    // Load the outgoing bits at start and shift one out at each slot end past the preamble.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sr <= '0;
            rd_q  <= 1'b0;
        end else if (start) begin
            tx_sr <= {CODE_START, (req_write ? CODE_WR : CODE_RD), req_phy, req_reg,
                      CODE_TA, (req_write ? req_wdata : {DATA_W{1'b0}})};
            rd_q  <= !req_write;
        end else if (tick && (phase == PH_LOW) && (slot >= HDR_SLOT)) begin
            tx_sr <= {tx_sr[FRAME_W-2:0], 1'b0};
        end
    end

    // Capture the error bit and then the data bits of a read, skipping data once an error is seen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_sr <= '0;
            err_q <= 1'b0;
        end else if (start) begin
            rx_sr <= '0;
            err_q <= 1'b0;
        end else if (sample) begin
            if (slot == ERR_SLOT)
                err_q <= mdi;
            else if ((slot >= DATA_SLOT) && !err_q)
                rx_sr <= {rx_sr[DATA_W-2:0], mdi};
        end
    end

    // Publish the result on the final edge of the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
            rd_err  <= 1'b0;
        end else if (finish) begin
            rd_data <= (rd_q && !err_q) ? rx_sr : '0;
            rd_err  <= rd_q && err_q;
        end
    end

    p_err_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err |-> (rd_data == '0));
endmodule

// File: rtl/phy_mgmt_master.sv
// Serial PHY management master top: accepts one request while idle and runs
// the preamble, header and tail of a management frame on the pins.
// Assumes an external pad combines mdo, md_oe and mdi into the data pin.
module phy_mgmt_master
    import pmm_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int PRE_N = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_phy,
    input  logic [ADDR_W-1:0] req_reg,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DIV_W-1:0]  div_cfg,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_err,
    output logic              mdc,
    output logic              mdo,
    output logic              md_oe,
    input  logic              mdi
);
    localparam int SLOTS  = PRE_N + FRAME_W;
    localparam int SLOT_W = $clog2(SLOTS);

    logic              start;
    logic              tick;
    logic              finish;
    logic              tx_bit;
    logic              drive;
    phase_t            phase;
    logic [SLOT_W-1:0] slot;

    assign start = req_valid && !busy;

    pmm_divider #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .start(start), .run(busy),
        .div_in(div_cfg), .tick(tick)
    );

    pmm_sequencer #(.PRE_N(PRE_N), .SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .tick(tick),
        .busy(busy), .done(done), .finish(finish), .phase(phase), .slot(slot)
    );

    pmm_shifter #(.PRE_N(PRE_N), .SLOT_W(SLOT_W)) u_shf (
        .clk(clk), .rst_n(rst_n), .start(start), .req_write(req_write),
        .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
        .tick(tick), .phase(phase), .slot(slot), .finish(finish), .mdi(mdi),
        .tx_bit(tx_bit), .drive(drive), .rd_data(rd_data), .rd_err(rd_err)
    );

    assign mdc   = busy && (phase == PH_HIGH);
    assign md_oe = !busy || drive;
    assign mdo   = !busy || !drive || tx_bit;

    p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy);
    p_pin_back_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (md_oe && done));
endmodule

// File: tb/sim_phy_mgmt_master.sv
// Bench: behavioural per-cycle expectation queue plus a PHY responder.
module sim_phy_mgmt_master;
    localparam int DW  = 4;
    localparam int PRE = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [4:0]  req_phy = '0, req_reg = '0;
    logic [15:0] req_wdata = '0;
    logic [DW-1:0] div_cfg = '0;
    logic        busy, done, rd_err, mdc, mdo, md_oe;
    logic        mdi = 1'b0;
    logic [15:0] rd_data;

    always #10 clk = ~clk;

    phy_mgmt_master #(.DIV_W(DW), .PRE_N(PRE)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
        .div_cfg(div_cfg), .busy(busy), .done(done), .rd_data(rd_data),
        .rd_err(rd_err), .mdc(mdc), .mdo(mdo), .md_oe(md_oe), .mdi(mdi)
    );

    logic [3:0]  qv[$];   // {mdc, mdo, md_oe, responder bit}
    string       qt[$];
    int          n_chk = 0, n_fail = 0;
    bit          done_exp = 0;
    logic [15:0] exp_data = '0;
    logic        exp_err = 1'b0;
    string       tag_ovr = "";
    int          cyc = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s act=%0h exp=%0h (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    // Expected pin values per cycle, from R3..R7.
    task automatic plan_frame(input bit wr, input logic [4:0] phy, input logic [4:0] rg,
                              input logic [15:0] wd, input logic [DW-1:0] dv,
                              input bit err, input logic [15:0] rdv);
        logic [31:0] tx;
        tx = {2'b01, (wr ? 2'b01 : 2'b10), phy, rg, 2'b10, (wr ? wd : 16'h0)};
        for (int s = 0; s < PRE + 32; s++) begin
            for (int ph = 0; ph < 3; ph++) begin
                for (int c = 0; c <= int'(dv); c++) begin
                    bit mc, oe, bv, mo, r;
                    string t;
                    mc = (ph == 1);
                    oe = !(!wr && s >= PRE + 14);
                    bv = (s < PRE) ? 1'b1 : tx[31 - (s - PRE)];
                    mo = oe ? bv : 1'b1;
                    if (!wr && s == PRE + 15)      r = err;
                    else if (!wr && s >= PRE + 16) r = rdv[15 - (s - PRE - 16)];
                    else                           r = 1'b1;
                    if (ph != 0) r = ~r;
                    if (s < PRE)           t = "R4";
                    else if (s < PRE + 14) t = "R5";
                    else if (wr)           t = "R6";
                    else                   t = "R7";
                    if (tag_ovr != "") t = tag_ovr;
                    qv.push_back({mc, mo, oe, r});
                    qt.push_back(t);
                end
            end
        end
        exp_data = (wr || err) ? 16'h0 : rdv;
        exp_err  = !wr && err;
    endtask

    task automatic step(input bit rq, input bit wr, input logic [4:0] phy,
                        input logic [4:0] rg, input logic [15:0] wd,
                        input logic [DW-1:0] dv, input bit err, input logic [15:0] rdv);
        bit busy_now;
        @(negedge clk);
        if (qv.size() > 0) begin
            logic [3:0] e;
            string t;
            e = qv.pop_front();
            t = qt.pop_front();
            chk(mdc == e[3], (tag_ovr != "") ? t : "R3", "mdc", mdc, e[3]);
            chk(mdo == e[2], t, "mdo", mdo, e[2]);
            chk(md_oe == e[1], t, "md_oe", md_oe, e[1]);
            chk(busy == 1'b1, "R2", "busy", busy, 1);
            chk(done == 1'b0, "R9", "done in frame", done, 0);
            mdi = e[0];
            if (qv.size() == 0) done_exp = 1;
            busy_now = 1;
        end else begin
            busy_now = 0;
            mdi = 1'b0;
            if (done_exp) begin
                chk(done == 1'b1, "R9", "done", done, 1);
                chk(busy == 1'b0, "R9", "busy at done", busy, 0);
                chk(md_oe == 1'b1, "R9", "md_oe at done", md_oe, 1);
                chk(rd_data == exp_data, exp_err ? "R8" : "R9", "rd_data", rd_data, exp_data);
                chk(rd_err == exp_err, exp_err ? "R8" : "R9", "rd_err", rd_err, exp_err);
            end else begin
                chk(busy == 1'b0, "R1", "busy idle", busy, 0);
                chk(done == 1'b0, "R1", "done idle", done, 0);
                chk(mdc == 1'b0, "R1", "mdc idle", mdc, 0);
                chk(mdo == 1'b1, "R1", "mdo idle", mdo, 1);
                chk(md_oe == 1'b1, "R1", "md_oe idle", md_oe, 1);
            end
            done_exp = 0;
        end
        req_valid = rq; req_write = wr; req_phy = phy; req_reg = rg;
        req_wdata = wd; div_cfg = dv;
        if (rq && !busy_now && rst_n) plan_frame(wr, phy, rg, wd, dv, err, rdv);
    endtask

    // One frame; div_cfg is flipped during it (R10), optional stray request (R10).
    task automatic run_frame(input bit wr, input logic [4:0] phy, input logic [4:0] rg,
                             input logic [15:0] wd, input logic [DW-1:0] dv,
                             input bit err, input logic [15:0] rdv, input bit stray);
        int k;
        tag_ovr = stray ? "R10" : "";
        step(1, wr, phy, rg, wd, dv, err, rdv);
        k = 0;
        while (qv.size() > 0) begin
            if (stray && k == 100) step(1, !wr, ~phy, ~rg, ~wd, dv, err, rdv);
            else step(0, wr, phy, rg, wd, dv ^ DW'(3), err, rdv);
            k++;
        end
        step(0, 0, 5'h0, 5'h0, 16'h0, dv, 0, 16'h0);   // done cycle
        step(0, 0, 5'h0, 5'h0, 16'h0, dv, 0, 16'h0);   // idle again (R1)
        tag_ovr = "";
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    initial begin : watchdog
        wait (cyc > 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired act=%0d exp=0", cyc);
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 3; i++) step(0, 0, 5'h0, 5'h0, 16'h0, 0, 0, 16'h0); // R1 reset state
        run_frame(1, 5'h11, 5'h0A, 16'hA5C3, 4'd1, 0, 16'h0, 0);    // write, R6
        run_frame(0, 5'h03, 5'h15, 16'h0,   4'd0, 0, 16'h9E71, 0);  // read, R7
        run_frame(0, 5'h1C, 5'h02, 16'h0,   4'd2, 1, 16'hFFFF, 0);  // read with error, R8
        run_frame(1, 5'h05, 5'h1F, 16'h0F0F, 4'd3, 0, 16'h0, 1);    // stray request, R10
        run_frame(0, 5'h1F, 5'h1F, 16'h0,   4'd1, 0, 16'h0001, 0);  // read, R5 all-ones address
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule